// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block traverses the chain of extended capability headers that sits in a 4 KB configuration space. It reaches that space through a synchronous single-port 32-bit memory. The memory is word addressed and returns read data one cycle after the request. A caller raises a one-cycle start pulse and supplies an operation. A lookup searches the chain for a capability identifier. It reports the offset of the matching header and the offset of the header visited just before it. An insert places a new header at a given offset. When that offset is the chain's base, the block rewrites the base header in place and keeps its link. At any other offset the block walks to the last header, relinks it to the new offset and then writes the new header.

Every header word has the same layout. The identifier is in bits [15:0], the version in bits [19:16] and the link to the next header in bits [31:20]. A link of zero ends the chain. The chain always starts at byte offset 0x100. An all-zero word there means the chain is empty. Identifier 0 is reserved and never matches, so a lookup for it stops at the last header. Corrupt links and cyclic chains end the operation with an error instead of hanging.

Top module: `cap_list_walker`

## Requirements
- R1: After reset, busy_o, done_o, err_o and mem_en_o are all 0.
- R2: A lookup returns the byte offset of the first header whose bits [15:0] equal the key in hit_off_o, and the offset visited before it (0 for the base header) in prev_off_o. Links are taken from bits [31:20] of each header.
- R3: A lookup that reaches a header with link 0 without a match returns hit_off_o = 0 and prev_off_o = the offset of that last header, with err_o = 0.
- R4: If the word at 0x100 is all zero, a lookup returns hit_off_o = 0, prev_off_o = 0 and err_o = 0.
- R5: A lookup for key 0 never matches and returns the last header's offset in prev_off_o.
- R6: A non-zero link below 0x100, above 0xFF8 or not a multiple of 4 ends the operation with err_o = 1 and hit_off_o = prev_off_o = 0. The memory is never read outside 0x100..0xFF8.
- R7: After the chain has been followed MAX_STEPS times without reaching an end or a match, the operation ends with err_o = 1.
- R8: An insert at 0x100 makes exactly one write to 0x100: the new identifier and version with the old link bits [31:20] kept. It returns hit_off_o = 0x100 and prev_off_o = 0.
- R9: An insert at any other offset writes the last header with its link replaced by the new offset and bits [19:0] kept. It then writes the new header with link 0. It returns hit_off_o = new offset and prev_off_o = last header offset.
- R10: An insert whose offset is below 0x100 or not a multiple of 4, whose size is below 8, or whose offset plus size is not below 0x1000 ends with err_o = 1 and no memory write. The same holds for an insert at a non-base offset into an empty chain.
- R11: done_o is a one-cycle pulse and busy_o is 0 while it is high. An accepted operation raises busy_o on the next cycle. A start while busy_o is 1 is ignored.
- R12: The memory is enabled only while busy_o is 1, and a lookup never writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request pulse |
| insert_i | input | 1 | 0 = lookup, 1 = insert |
| cap_id_i | input | 16 | Key to find, or identifier to insert |
| cap_ver_i | input | 4 | Version of inserted header |
| cap_off_i | input | 12 | Byte offset of inserted header |
| cap_size_i | input | 13 | Byte size of inserted capability |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Last operation failed |
| hit_off_o | output | 12 | Found or inserted offset, else 0 |
| prev_off_o | output | 12 | Previously visited or last header offset |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 10 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read |

## Verification
The embedded properties check these rules on every cycle: the handshake shape, the quiet memory port while idle, the read window 0x100..0xFF8, the zeroed results on error, the bound on the step counter and the back-to-back write pair of a tail insert. The bench scenarios are the only place that shows which offsets the walk reports for matches, empty chains, key 0, corrupt links and cycles. They are also the only place that shows the exact header words an insert leaves in memory, and that rejected inserts write nothing.

// File: rtl/cap_walk_pkg.sv
package cap_walk_pkg;
  localparam int OFF_W  = 12;
  localparam int AW     = OFF_W - 2;
  localparam int SIZE_W = OFF_W + 1;
  localparam int ID_W   = 16;
  localparam int VER_W  = 4;

  typedef struct packed {
    logic [OFF_W-1:0] link;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } cap_hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_LINK,
    ST_PLACE
  } walk_state_t;
endpackage

// File: rtl/cap_hdr_decode.sv
module cap_hdr_decode
  import cap_walk_pkg::*;
#(
  parameter int BASE_OFF = 'h100
) (
  input  logic [ID_W-1:0]  id_i,
  input  logic [OFF_W-1:0] link_i,
  input  logic [ID_W-1:0]  key_i,
  output logic             hit_o,
  output logic             end_o,
  output logic             bad_o
);
  localparam logic [OFF_W-1:0] LO_L = OFF_W'(BASE_OFF);
  localparam logic [OFF_W-1:0] HI_L = OFF_W'((1 << OFF_W) - 8);

  always_comb begin
    hit_o = (key_i != '0) && (id_i == key_i);
    end_o = (link_i == '0);
    bad_o = !end_o && ((link_i < LO_L) || (link_i > HI_L) || (link_i[1:0] != 2'b00));
  end
endmodule

// File: rtl/cap_step_ctr.sv
module cap_step_ctr #(
  parameter int MAX_STEPS = 1024,
  localparam int STEP_W = $clog2(MAX_STEPS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [STEP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + STEP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr_i || inc_i)  cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == STEP_W'(MAX_STEPS - 1));

  p_step_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= STEP_W'(MAX_STEPS - 1));
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |-> !last_o);
endmodule

// File: rtl/cap_list_walker.sv
module cap_list_walker
  import cap_walk_pkg::*;
#(
  parameter int BASE_OFF  = 'h100,
  parameter int MAX_STEPS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              insert_i,
  input  logic [ID_W-1:0]   cap_id_i,
  input  logic [VER_W-1:0]  cap_ver_i,
  input  logic [OFF_W-1:0]  cap_off_i,
  input  logic [SIZE_W-1:0] cap_size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [OFF_W-1:0]  hit_off_o,
  output logic [OFF_W-1:0]  prev_off_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  localparam logic [OFF_W-1:0]  BASE_L  = OFF_W'(BASE_OFF);
  localparam logic [OFF_W-1:0]  LAST_L  = OFF_W'((1 << OFF_W) - 8);
  localparam logic [SIZE_W:0]   SPACE_L = (SIZE_W + 1)'(1 << OFF_W);
  localparam logic [SIZE_W-1:0] MIN_SZ  = SIZE_W'(8);

  walk_state_t      state_q, state_d;
  logic             ins_q, ins_d, base_q, base_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [VER_W-1:0] ver_q, ver_d;
  logic [OFF_W-1:0] off_q, off_d, cur_q, cur_d, prv_q, prv_d;
  cap_hdr_t         hdr_q, hdr_d, rd_hdr;
  logic [OFF_W-1:0] hit_q, hit_d, pout_q, pout_d;
  logic             err_q, err_d, done_q, done_d;
  logic             step_clr, step_inc, step_last;
  logic             dec_hit, dec_end, dec_bad;
  logic             args_ok;
  logic [SIZE_W:0]  end_sum;
  logic [ID_W-1:0]  key;

  assign rd_hdr  = cap_hdr_t'(mem_rdata_i);
  assign key     = ins_q ? '0 : id_q;
  assign end_sum = {2'b00, cap_off_i} + {1'b0, cap_size_i};
  assign args_ok = (cap_off_i >= BASE_L) && (cap_off_i[1:0] == 2'b00) &&
                   (cap_size_i >= MIN_SZ) && (end_sum < SPACE_L);

  cap_hdr_decode #(.BASE_OFF(BASE_OFF)) u_dec (
    .id_i   (rd_hdr.id),
    .link_i (rd_hdr.link),
    .key_i  (key),
    .hit_o  (dec_hit),
    .end_o  (dec_end),
    .bad_o  (dec_bad)
  );

  cap_step_ctr #(.MAX_STEPS(MAX_STEPS)) u_steps (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (step_clr),
    .inc_i  (step_inc),
    .last_o (step_last)
  );

  // next-state logic
  always_comb begin
    state_d = state_q; ins_d = ins_q; base_d = base_q;
    id_d = id_q; ver_d = ver_q; off_d = off_q;
    cur_d = cur_q; prv_d = prv_q; hdr_d = hdr_q;
    hit_d = hit_q; pout_d = pout_q; err_d = err_q;
    done_d = 1'b0; step_clr = 1'b0; step_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        ins_d = insert_i; id_d = cap_id_i; ver_d = cap_ver_i; off_d = cap_off_i;
        base_d = insert_i && (cap_off_i == BASE_L);
        cur_d = BASE_L; prv_d = '0; step_clr = 1'b1;
        hit_d = '0; pout_d = '0; err_d = 1'b0;
        if (insert_i && !args_ok) begin
          err_d = 1'b1; done_d = 1'b1;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_READ: state_d = ST_CHECK;
      ST_CHECK: begin
        if (base_q) begin
          hdr_d = rd_hdr; state_d = ST_PLACE;
        end else if ((cur_q == BASE_L) && (mem_rdata_i == '0)) begin
          err_d = ins_q; done_d = 1'b1; state_d = ST_IDLE;
        end else if (dec_hit) begin
          hit_d = cur_q; pout_d = prv_q; done_d = 1'b1; state_d = ST_IDLE;
        end else if (dec_end) begin
          pout_d = cur_q;
          if (ins_q) begin
            hdr_d = rd_hdr; state_d = ST_LINK;
          end else begin
            done_d = 1'b1; state_d = ST_IDLE;
          end
        end else if (dec_bad || step_last) begin
          err_d = 1'b1; done_d = 1'b1; state_d = ST_IDLE;
        end else begin
          prv_d = cur_q; cur_d = rd_hdr.link; step_inc = 1'b1; state_d = ST_READ;
        end
      end
      ST_LINK: state_d = ST_PLACE;
      ST_PLACE: begin
        hit_d = off_q; done_d = 1'b1; state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // memory port drive
  always_comb begin
    mem_en_o = 1'b0; mem_we_o = 1'b0;
    mem_addr_o = cur_q[OFF_W-1:2]; mem_wdata_o = '0;
    unique case (state_q)
      ST_READ: mem_en_o = 1'b1;
      ST_LINK: begin
        mem_en_o = 1'b1; mem_we_o = 1'b1;
        mem_wdata_o = {off_q, hdr_q.ver, hdr_q.id};
      end
      ST_PLACE: begin
        mem_en_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = off_q[OFF_W-1:2];
        mem_wdata_o = {hdr_q.link, ver_q, id_q};
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; ins_q <= 1'b0; base_q <= 1'b0;
      id_q <= '0; ver_q <= '0; off_q <= '0; cur_q <= '0; prv_q <= '0;
      hdr_q <= '0; hit_q <= '0; pout_q <= '0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      state_q <= state_d; done_q <= done_d;
      if (state_q == ST_IDLE && start_i) begin
        ins_q <= ins_d; base_q <= base_d; id_q <= id_d; ver_q <= ver_d; off_q <= off_d;
      end
      if (state_q != ST_READ) begin
        cur_q <= cur_d; prv_q <= prv_d; hdr_q <= hdr_d;
        hit_q <= hit_d; pout_q <= pout_d; err_q <= err_d;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign hit_off_o  = hit_q;
  assign prev_off_o = pout_q;

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_en_o);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_start_takes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (!insert_i || args_ok)) |=> busy_o);
  p_read_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o) |-> ((mem_addr_o >= BASE_L[OFF_W-1:2]) &&
                                 (mem_addr_o <= LAST_L[OFF_W-1:2])));
  p_err_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (hit_off_o == '0) && (prev_off_o == '0));
  p_tail_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && state_q == ST_LINK) |=> (mem_we_o && mem_addr_o == off_q[OFF_W-1:2]));
endmodule

// File: tb/cap_list_walker_tb.sv
`timescale 1ns/1ps
module cap_list_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, insert_i = 1'b0;
  logic [15:0] cap_id_i = '0;
  logic [3:0]  cap_ver_i = '0;
  logic [11:0] cap_off_i = '0;
  logic [12:0] cap_size_i = '0;
  logic        busy_o, done_o, err_o, mem_en_o, mem_we_o;
  logic [11:0] hit_off_o, prev_off_o;
  logic [9:0]  mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  always #2 clk = ~clk;

  cap_list_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insert_i(insert_i),
    .cap_id_i(cap_id_i), .cap_ver_i(cap_ver_i), .cap_off_i(cap_off_i),
    .cap_size_i(cap_size_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .hit_off_o(hit_off_o), .prev_off_o(prev_off_o), .mem_en_o(mem_en_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  logic [31:0] ram [1024];
  int wr_cnt = 0;
  always @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) begin
        ram[mem_addr_o] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata_i <= ram[mem_addr_o];
      end
    end
  end

  int n_chk = 0, n_fail = 0, done_cnt = 0;

  typedef struct {
    logic [11:0] hit;
    logic [11:0] prv;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic logic [31:0] mk(input logic [11:0] n, input logic [3:0] v, input logic [15:0] i);
    return {n, v, i};
  endfunction

  task automatic fail_line(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_fail++;
    $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) fail_line(tag, act, exp);
  endtask

  // monitor: pops expected results as completions appear
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      done_cnt++;
      if (sb_q.size() == 0) begin
        n_chk++;
        fail_line("R11 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " hit"}, {20'd0, hit_off_o}, {20'd0, e.hit});
        check({e.tag, " prev"}, {20'd0, prev_off_o}, {20'd0, e.prv});
        check({e.tag, " err"}, {31'd0, err_o}, {31'd0, e.err});
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    fail_line("watchdog expired", 32'd1, 32'd0);
    summary();
    $finish;
  end

  task automatic clear_ram();
    for (int k = 0; k < 1024; k++) ram[k] = '0;
  endtask

  task automatic put(input logic [11:0] off, input logic [31:0] w);
    ram[off[11:2]] = w;
  endtask

  task automatic run(input logic ins, input logic [15:0] id, input logic [3:0] ver,
                     input logic [11:0] off, input logic [12:0] sz,
                     input logic [11:0] eh, input logic [11:0] ep, input logic ee,
                     input string tag);
    exp_t e;
    e.hit = eh; e.prv = ep; e.err = ee; e.tag = tag;
    sb_q.push_back(e);
    insert_i = ins; cap_id_i = id; cap_ver_i = ver; cap_off_i = off; cap_size_i = sz;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic build_a();
    clear_ram();
    put(12'h100, mk(12'h140, 4'd1, 16'h0001));
    put(12'h140, mk(12'h200, 4'd1, 16'h000E));
    put(12'h200, mk(12'h000, 4'd1, 16'h0010));
  endtask

  initial begin
    int w0;
    clear_ram();
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy_o}, 32'd0);
    check("R1 done", {31'd0, done_o}, 32'd0);
    check("R1 err", {31'd0, err_o}, 32'd0);
    check("R1 mem_en", {31'd0, mem_en_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    build_a();
    w0 = wr_cnt;
    run(0, 16'h0001, 0, 0, 0, 12'h100, 12'h000, 0, "R2 base match");
    run(0, 16'h000E, 0, 0, 0, 12'h140, 12'h100, 0, "R2 middle match");
    run(0, 16'h0010, 0, 0, 0, 12'h200, 12'h140, 0, "R2 last match");
    run(0, 16'h0055, 0, 0, 0, 12'h000, 12'h200, 0, "R3 miss");
    run(0, 16'h0000, 0, 0, 0, 12'h000, 12'h200, 0, "R5 key zero");
    check("R12 lookup writes", wr_cnt, w0);

    clear_ram();
    run(0, 16'h0001, 0, 0, 0, 12'h000, 12'h000, 0, "R4 empty");

    clear_ram();
    put(12'h100, mk(12'hFF8, 4'd1, 16'h0001));
    put(12'hFF8, mk(12'h000, 4'd1, 16'h0007));
    run(0, 16'h0007, 0, 0, 0, 12'hFF8, 12'h100, 0, "R6 top edge ok");
    clear_ram();
    put(12'h100, mk(12'h0F0, 4'd1, 16'h0001));
    run(0, 16'h0009, 0, 0, 0, 12'h000, 12'h000, 1, "R6 link low");
    put(12'h100, mk(12'h142, 4'd1, 16'h0001));
    run(0, 16'h0009, 0, 0, 0, 12'h000, 12'h000, 1, "R6 link misaligned");
    put(12'h100, mk(12'hFFC, 4'd1, 16'h0001));
    run(0, 16'h0009, 0, 0, 0, 12'h000, 12'h000, 1, "R6 link high");

    clear_ram();
    put(12'h100, mk(12'h110, 4'd1, 16'h0001));
    put(12'h110, mk(12'h100, 4'd1, 16'h0002));
    run(0, 16'h0033, 0, 0, 0, 12'h000, 12'h000, 1, "R7 cycle");

    build_a();
    w0 = wr_cnt;
    run(1, 16'h000B, 4'd3, 12'h300, 13'd16, 12'h300, 12'h200, 0, "R9 tail insert");
    check("R9 write count", wr_cnt - w0, 2);
    check("R9 tail relinked", ram[12'h200 >> 2], mk(12'h300, 4'd1, 16'h0010));
    check("R9 new header", ram[12'h300 >> 2], mk(12'h000, 4'd3, 16'h000B));
    run(0, 16'h000B, 0, 0, 0, 12'h300, 12'h200, 0, "R9 find inserted");

    build_a();
    w0 = wr_cnt;
    run(1, 16'h000C, 4'd2, 12'h100, 13'd8, 12'h100, 12'h000, 0, "R8 base insert");
    check("R8 write count", wr_cnt - w0, 1);
    check("R8 base header", ram[12'h100 >> 2], mk(12'h140, 4'd2, 16'h000C));
    run(0, 16'h000E, 0, 0, 0, 12'h140, 12'h100, 0, "R8 chain intact");

    build_a();
    w0 = wr_cnt;
    run(1, 16'h000D, 4'd1, 12'h0F0, 13'd16, 12'h000, 12'h000, 1, "R10 offset low");
    run(1, 16'h000D, 4'd1, 12'h302, 13'd16, 12'h000, 12'h000, 1, "R10 offset misaligned");
    run(1, 16'h000D, 4'd1, 12'h300, 13'd4,  12'h000, 12'h000, 1, "R10 size small");
    run(1, 16'h000D, 4'd1, 12'hFF0, 13'd16, 12'h000, 12'h000, 1, "R10 end at limit");
    check("R10 no writes", wr_cnt - w0, 0);
    check("R10 tail untouched", ram[12'h200 >> 2], mk(12'h000, 4'd1, 16'h0010));
    clear_ram();
    w0 = wr_cnt;
    run(1, 16'h000D, 4'd1, 12'h300, 13'd16, 12'h000, 12'h000, 1, "R10 empty chain");
    check("R10 empty no writes", wr_cnt - w0, 0);

    build_a();
    begin
      exp_t e;
      int d0;
      d0 = done_cnt;
      e.hit = 12'h200; e.prv = 12'h140; e.err = 1'b0; e.tag = "R11 busy start";
      sb_q.push_back(e);
      insert_i = 0; cap_id_i = 16'h0010; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R11 busy raised", {31'd0, busy_o}, 32'd1);
      @(negedge clk);
      cap_id_i = 16'h0001; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o) @(negedge clk);
      repeat (12) @(negedge clk);
      check("R11 single completion", done_cnt - d0, 1);
    end

    summary();
    $finish;
  end
endmodule